// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Gate Generator

This block drives one leg of a five-level inverter that uses two series DC sources, two source-select switches and a four-switch bridge. Each clock it compares a signed reference sample with four triangular carriers, one per stacked amplitude band. From those comparisons it picks an output level between -2 and +2, then decodes that level into six gate lines.

A mode input sets the relative phase of the carriers. In the in-phase arrangement all four carriers move together. In the alternating arrangement, neighbouring carriers move in opposite directions. In the split arrangement, the pair above zero moves opposite to the pair below zero.

The reference can come from an external port. It can also come from an internal sine generator, which advances one step per carrier period and is scaled by a modulation index. A programmable dead time separates turning a switch off from turning any switch on. The decoded level only changes once that wait is over.

Top module: `mlpwm_gate`

## Requirements
- R1: A shared triangle count c starts at 0 on reset release. It moves up by one each clock to BAND, then down by one to 0, so its period is 2*BAND clocks. Carrier k (k = 0..3, from bottom to top) lives in the band from (k-2)*BAND to (k-1)*BAND.
- R2: An in-phase carrier equals (k-2)*BAND + c. An opposite-phase carrier equals (k-2)*BAND + BAND - c, which starts at the top of its band and moves down.
- R3: With mode 0, and also with mode 3, all four carriers are in phase.
- R4: With mode 1, carriers 1 and 3 are opposite-phase and carriers 0 and 2 are in phase.
- R5: With mode 2, carriers 0 and 1 (below zero) are opposite-phase and carriers 2 and 3 are in phase.
- R6: The target level is the number of carriers that the reference strictly exceeds (signed compare), minus 2. The `level` port carries it as 3-bit two's complement.
- R7: Gate bits: bit0 = lower-source select, bit1 = stacked-source select, bit2/bit3 = high/low switch of bridge side A, bit4/bit5 = high/low switch of bridge side B. The patterns are +2 = 100110, +1 = 100101, 0 = 010100, -1 = 011001 and -2 = 011010 (written bit5 first).
- R8: Bits 0 and 1 are never on together. Bits 2 and 3 are never on together. Bits 4 and 5 are never on together.
- R9: A transition starts on an edge when no wait is pending and either the target differs from `level` or `gate` differs from the pattern for `level`. If `dead_clks` = 0, the new pattern and level take effect on that edge. Otherwise, on that edge only the bits absent from the new pattern clear. The full pattern and the new level then appear `dead_clks` edges later. Target changes during the wait are ignored until it ends.
- R10: While reset is asserted, `gate` = 0 and `level` = 0, and the carriers and sine phase restart. The first edge after release begins a transition (R9) to the pattern of the current target.
- R11: With `ref_sel` = 0, the reference is floor(s*mod_idx / 2^MIW). The phase p (0..4*LUT_N-1, reset 0) advances on each edge where c = 0 and rising. With r = p mod LUT_N and quadrant q = p / LUT_N, the index is r for even q and LUT_N - r for odd q. The sign is negative for q >= 2. The magnitude for index i uses d = 90*i/LUT_N degrees: floor(2*BAND*4*d*(180-d) / (40500 - d*(180-d))). LUT_N is a power of two.
- R12: With `ref_sel` = 1, the reference is the signed `ext_ref` port, sampled combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Carrier phase arrangement (0/3 in-phase, 1 alternating, 2 split) |
| ref_sel | input | 1 | 1 selects external reference, 0 the internal sine |
| ext_ref | input | RW ($clog2(2*BAND+1)+1) | Signed external reference sample |
| mod_idx | input | MIW | Unsigned modulation index, scale mod_idx/2^MIW |
| dead_clks | input | DW | Dead time in clocks |
| gate | output | 6 | Switch gate drives, encoding in R7 |
| level | output | 3 | Decoded output level, signed |

## Verification
The bench builds the block with BAND = 8, LUT_N = 8 and DW = 4. With these values a carrier period is 16 clocks and a full sine cycle is 512 clocks. The bench sweeps every reference value across the whole carrier span, plus one step beyond each end, over a complete carrier period in each of the four mode codes. This reaches every crossing of every carrier in every arrangement. Dead times of 0, 1, 2, 3 and 6 are exercised with references that change during the wait. Whole sine cycles are run at three modulation indices, so every table entry and quadrant is checked against an arithmetic model.

// File: rtl/mlpwm_gate.sv
module mlpwm_gate #(
  parameter int BAND  = 16,
  parameter int LUT_N = 16,
  parameter int MIW   = 8,
  parameter int DW    = 4,
  localparam int RW = $clog2(2*BAND+1) + 1,
  localparam int CW = $clog2(BAND+1),
  localparam int PW = $clog2(LUT_N) + 2,
  localparam int IW = $clog2(LUT_N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 ref_sel,
  input  logic signed [RW-1:0] ext_ref,
  input  logic [MIW-1:0]       mod_idx,
  input  logic [DW-1:0]        dead_clks,
  output logic [5:0]           gate,
  output logic [2:0]           level
);

  // shared triangle count
  logic [CW-1:0] cnt;
  logic          up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(BAND-1)) up <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) up <= 1'b1;
    end

  // internal sine
  logic [PW-1:0] sph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sph <= '0;
    else if (up && cnt == '0) sph <= sph + 1'b1;

  function automatic int qsin(int i);
    longint d, s, p;
    d = longint'(90) * i;
    s = longint'(180) * LUT_N;
    p = d * (s - d);
    return int'((longint'(8) * BAND * p) / (longint'(40500) * LUT_N * LUT_N - p));
  endfunction

  logic signed [RW-1:0] qtab [LUT_N+1];
  for (genvar i = 0; i <= LUT_N; i++) begin : g_tab
    assign qtab[i] = RW'(qsin(i));
  end

  wire [1:0]    quad = sph[PW-1:PW-2];
  wire [IW-1:0] roff = {1'b0, sph[PW-3:0]};
  wire [IW-1:0] idx  = quad[0] ? IW'(LUT_N) - roff : roff;
  wire signed [RW-1:0] mag   = qtab[idx];
  wire signed [RW-1:0] sin_v = quad[1] ? -mag : mag;

  logic signed [RW+MIW:0] prod;
  assign prod = sin_v * $signed({1'b0, mod_idx});
  wire signed [RW-1:0] ref_int = RW'(prod >>> MIW);
  wire signed [RW-1:0] ref_v   = ref_sel ? ext_ref : ref_int;
  wire signed [RW:0]   ref_x   = {ref_v[RW-1], ref_v};

  // carrier compare
  wire signed [RW:0] c_ext = $signed({{(RW+1-CW){1'b0}}, cnt});
  logic [3:0] hit;

  for (genvar k = 0; k < 4; k++) begin : g_car
    localparam logic signed [RW:0] BASE = (RW+1)'((k-2)*BAND);
    localparam logic signed [RW:0] TOP  = (RW+1)'(BAND);
    localparam bit ODD = (k % 2) == 1;
    localparam bit LOW = k < 2;
    logic flip;
    always_comb
      case (mode)
        2'd1:    flip = ODD;
        2'd2:    flip = LOW;
        default: flip = 1'b0;
      endcase
    wire signed [RW:0] car = BASE + (flip ? TOP - c_ext : c_ext);
    assign hit[k] = ref_x > car;
  end

  wire [2:0] tgt = 3'($countones(hit)) - 3'd2;

  function automatic logic [5:0] pat(logic [2:0] l);
    case (l)
      3'b010:  return 6'b100110;
      3'b001:  return 6'b100101;
      3'b111:  return 6'b011001;
      3'b110:  return 6'b011010;
      default: return 6'b010100;
    endcase
  endfunction

  // dead-time sequencer
  logic [2:0]    pend;
  logic [DW-1:0] dcnt;
  wire busy = dcnt != '0;
  wire want = (tgt != level) || (gate != pat(level));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gate  <= '0;
      level <= '0;
      pend  <= '0;
      dcnt  <= '0;
    end else if (busy) begin
      dcnt <= dcnt - 1'b1;
      if (dcnt == DW'(1)) begin
        gate  <= pat(pend);
        level <= pend;
      end
    end else if (want) begin
      if (dead_clks == '0) begin
        gate  <= pat(tgt);
        level <= tgt;
      end else begin
        gate <= gate & pat(tgt);
        pend <= tgt;
        dcnt <= dead_clks;
      end
    end

endmodule

// File: rtl/mlpwm_gate_chk.sv
module mlpwm_gate_chk #(
  parameter int BAND = 16,
  parameter int CW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    gate,
  input logic [2:0]    level,
  input logic [CW-1:0] cnt
);

  function automatic logic [5:0] lvl_pat(logic [2:0] l);
    case (l)
      3'b010:  return 6'b100110;
      3'b001:  return 6'b100101;
      3'b111:  return 6'b011001;
      3'b110:  return 6'b011010;
      default: return 6'b010100;
    endcase
  endfunction

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R8
  legs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]) && !(gate[4] && gate[5]));

  // R9
  gate_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate & ~lvl_pat(level)) == 6'b0);

  // R9
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && level != $past(level)) |-> gate == lvl_pat(level));

  // R1
  tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (int'(cnt) <= BAND &&
              (int'(cnt) - int'($past(cnt)) == 1 || int'($past(cnt)) - int'(cnt) == 1)));

  // R10
  reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gate == 6'b0 && level == 3'b0 && cnt == '0));

endmodule

bind mlpwm_gate mlpwm_gate_chk #(.BAND(BAND), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate(gate), .level(level), .cnt(cnt)
);

// File: tb/mlpwm_gate_tb_top.sv
`timescale 1ns/1ps
module mlpwm_gate_tb_top;
  localparam int BAND  = 8;
  localparam int LUT_N = 8;
  localparam int MIW   = 8;
  localparam int DW    = 4;
  localparam int RW    = $clog2(2*BAND+1) + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic [1:0]           mode = 2'd0;
  logic                 ref_sel = 1'b1;
  logic signed [RW-1:0] ext_ref = '0;
  logic [MIW-1:0]       mod_idx = '0;
  logic [DW-1:0]        dead_clks = '0;
  logic [5:0]           gate;
  logic [2:0]           level;

  mlpwm_gate #(.BAND(BAND), .LUT_N(LUT_N), .MIW(MIW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref_sel(ref_sel), .ext_ref(ext_ref),
    .mod_idx(mod_idx), .dead_clks(dead_clks), .gate(gate), .level(level)
  );

  int checks = 0;
  int failures = 0;

  function automatic int tri_c(int tt);
    int m = tt % (2*BAND);
    return (m <= BAND) ? m : 2*BAND - m;
  endfunction

  function automatic int tgt_of(int rv, int md, int tt);
    int c = tri_c(tt);
    int n = 0;
    for (int k = 0; k < 4; k++) begin
      bit flip;
      int car;
      flip = (md == 1) ? (k % 2 == 1) : (md == 2) ? (k < 2) : 1'b0;
      car = (k-2)*BAND + (flip ? BAND - c : c);
      if (rv > car) n++;
    end
    return n - 2;
  endfunction

  function automatic logic [5:0] pat(int l);
    case (l)
      2:       return 6'b100110;
      1:       return 6'b100101;
      -1:      return 6'b011001;
      -2:      return 6'b011010;
      default: return 6'b010100;
    endcase
  endfunction

  function automatic int qmag(int i);
    longint d, s, p;
    d = longint'(90) * i;
    s = longint'(180) * LUT_N;
    p = d * (s - d);
    return int'((longint'(8) * BAND * p) / (longint'(40500) * LUT_N * LUT_N - p));
  endfunction

  function automatic int sine_of(int p);
    int q = p / LUT_N;
    int r = p % LUT_N;
    int m = qmag((q % 2 == 1) ? LUT_N - r : r);
    return (q >= 2) ? -m : m;
  endfunction

  // reference model state
  int t = 0, sph = 0, m_cur = 0, m_pend = 0, m_dcnt = 0;
  logic [5:0] m_g = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; sph = 0; m_cur = 0; m_pend = 0; m_dcnt = 0; m_g = '0;
    end else begin
      int rv, tg;
      rv = ref_sel ? int'(ext_ref) : ((sine_of(sph) * int'(mod_idx)) >>> MIW);
      tg = tgt_of(rv, int'(mode), t);
      if (m_dcnt > 0) begin
        m_dcnt--;
        if (m_dcnt == 0) begin m_g = pat(m_pend); m_cur = m_pend; end
      end else if (tg != m_cur || m_g != pat(m_cur)) begin
        if (dead_clks == 0) begin m_g = pat(tg); m_cur = tg; end
        else begin m_g = m_g & pat(tg); m_pend = tg; m_dcnt = int'(dead_clks); end
      end
      if (t % (2*BAND) == 0) sph = (sph + 1) % (4*LUT_N);
      t++;
    end
  end

  task automatic check_out(string tag);
    checks++;
    if (int'($signed(level)) != m_cur || gate != m_g) begin
      failures++;
      $display("FAIL %s level=%0d exp=%0d gate=%b exp=%b t=%0d", tag,
               int'($signed(level)), m_cur, gate, m_g, t);
    end
    checks++;
    if ((gate[0] && gate[1]) || (gate[2] && gate[3]) || (gate[4] && gate[5])) begin
      failures++;
      $display("FAIL R8 gate=%b exp=no leg conflict", gate);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_out(tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (gate != 6'b0 || level != 3'b0) begin
        failures++;
        $display("FAIL R10 gate=%b level=%0d exp gate=000000 level=0", gate, level);
      end
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(8*150000);
    failures++;
    $display("FAIL watchdog expired checks=%0d exp=completion", checks);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    run(4, "R10 first transition");

    // R3 R4 R5 R6 R7 R12: exhaustive ext reference sweep per mode, R1 R2 carriers
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md);
      for (int r = -2*BAND-1; r <= 2*BAND+1; r++) begin
        ext_ref = RW'(r);
        case (md)
          0: run(2*BAND, "R1 R2 R3 R6 R7 R12 pd");
          1: run(2*BAND, "R1 R2 R4 R6 R7 R12 apod");
          2: run(2*BAND, "R1 R2 R5 R6 R7 R12 pod");
          default: run(2*BAND, "R3 mode3 alias");
        endcase
      end
    end

    // R9 dead time with references changing during the wait
    for (int j = 0; j < 4; j++) begin
      int dv = (j == 0) ? 1 : (j == 1) ? 3 : (j == 2) ? 6 : 2;
      dead_clks = DW'(dv);
      mode = 2'(j % 3);
      for (int i = 0; i < 60; i++) begin
        ext_ref = RW'(((i*7) % (4*BAND+3)) - (2*BAND+1));
        run((i % 4) + 1, "R9 dead time");
      end
    end

    // R10 mid-run reset with dead time active
    dead_clks = DW'(3);
    do_reset();
    run(8, "R10 R9 restart");

    // R11 internal sine at several indices
    ref_sel = 1'b0;
    dead_clks = DW'(2);
    mode = 2'd1; mod_idx = 8'd255;
    run(2*4*LUT_N*2*BAND, "R11 sine mi=255");
    mode = 2'd0; mod_idx = 8'd128; dead_clks = DW'(0);
    run(4*LUT_N*2*BAND, "R11 sine mi=128");
    mode = 2'd2; mod_idx = 8'd0;
    run(4*LUT_N*2*BAND, "R11 sine mi=0");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule